// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a pair of 24-bit two's-complement audio samples each frame over a three-wire serial link. The link has a frame clock that tells the left channel from the right, a bit clock, and one data line. All logic runs on a single system clock. The block's master clock arrives as a one-cycle enable pulse, `mclk_tick_i`, once per master-clock period. External serial clocks are brought in through a synchronizer.

A two-bit clock mode picks between two ways of clocking:
- In the master modes the block divides the master clock down by 128, 256 or 512 to produce the frame clock. It produces a bit clock of 64 periods per frame and drives both clocks out.
- In the slave mode the block ignores the master clock and follows a frame clock and a bit clock supplied from outside. That bit clock has 48 or 32 periods per frame.

A format select picks left-justified framing (MSB in the first slot after a frame-clock edge) or I2S framing (MSB one slot later). The clock mode and the format are captured only while the power-down input is high.

Samples enter through a valid/ready handshake into a one-pair holding buffer. The buffered pair is taken at the start of the next frame. If no new pair has arrived by then, the previous pair is sent again.

Top module: `sao_serial_out`

## Requirements
- R1: Clock mode 00 is master with 256 master-clock periods per frame, 10 is master with 512, and 11 is master with 128. In every master mode the bit clock has 64 periods per frame and `clk_drive_o` is high.
- R2: Clock mode 01 is slave. `mclk_tick_i` has no effect, `bclk_o`, `lrck_o` and `clk_drive_o` stay low, and the slot timing follows `bclk_i` and `lrck_i`.
- R3: Each channel is sent MSB first as a 24-bit two's-complement word. The left word is sent in the first half of the frame and the right word in the second half. Every slot after the last sent bit of a half is 0.
- R4: The data line changes only on a falling edge of the bit clock. In master mode `sdata_o` changes in the same system cycle in which `bclk_o` goes low. The receiver samples on the rising edge.
- R5: With `fmt_i2s_i` = 0 (left-justified), the frame clock is high for the left half and low for the right half. The MSB occupies slot 0, the first bit clock after the frame-clock edge.
- R6: With `fmt_i2s_i` = 1 (I2S), the frame clock is low for the left half and high for the right half. Slot 0 is 0 and the MSB occupies slot 1.
- R7: In slave mode, sample bits that would fall past the end of a half are dropped. With 16 slots per half (32 bit clocks per frame), left-justified framing sends the upper 16 bits. With 24 slots per half, I2S framing sends bits 23 down to 1.
- R8: `in_ready_o` is high while the block is powered up and the holding buffer is empty. A pair accepted on `in_valid_i && in_ready_o` is sent starting at the next frame start. Without a new pair, the last pair is repeated.
- R9: `clk_mode_i` and `fmt_i2s_i` are captured only while `pd_i` is high. Changes made while `pd_i` is low do not affect framing until the next power-down.
- R10: While `pd_i` is high, `sdata_o`, `bclk_o`, `lrck_o` and `in_ready_o` are low, all counters are reset, and the holding buffer and the current pair are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Power-down; configuration is captured while high |
| clk_mode_i | input | 2 | Clocking mode select (see R1, R2) |
| fmt_i2s_i | input | 1 | 0 = left-justified framing, 1 = I2S framing |
| mclk_tick_i | input | 1 | One-cycle pulse per master-clock period |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| clk_drive_o | output | 1 | High when the block drives the serial clocks |
| sdata_o | output | 1 | Serial data |
| in_valid_i | input | 1 | Sample pair valid |
| in_ready_o | output | 1 | Holding buffer can take a pair |
| in_left_i | input | 24 | Left sample |
| in_right_i | input | 24 | Right sample |

## Verification
A wrong divider or slot counter shows up within one frame. It appears as a frame whose length differs from the selected ratio, or as a frame-clock transition that does not fall on the 64th bit clock. A wrong bit offset or polarity shifts every captured word by one slot, or swaps the channels, in the first frame after power-up. A stale holding buffer shows as an old pair repeated one frame after a new pair was accepted. A configuration register that tracks its inputs while running changes the frame length or polarity in the next frame.

// File: rtl/sao_pkg.sv
package sao_pkg;

   typedef enum logic [1:0] {
      CLK_M256  = 2'b00,
      CLK_SLAVE = 2'b01,
      CLK_M512  = 2'b10,
      CLK_M128  = 2'b11
   } clk_mode_e;

   localparam int BCLK_PER_FRAME = 64;
   localparam int SLOT_W         = $clog2(BCLK_PER_FRAME);
   localparam int HALF_SLOTS     = BCLK_PER_FRAME / 2;
   localparam int K_W            = $clog2(HALF_SLOTS);
   localparam int DIV_W          = 3;

endpackage

// File: rtl/sao_master_gen.sv
module sao_master_gen
   import sao_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  mclk_tick,
   input  clk_mode_e             mode,
   input  logic                  i2s,
   output logic                  ev,
   output logic [SLOT_W-1:0]     ev_slot,
   output logic                  bclk,
   output logic                  lrck
);

   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_last;
   logic [SLOT_W-1:0] slot_q;
   logic              bclk_q;
   logic              lr_q;
   logic              toggle;

   // master-clock ticks per bit-clock half period = ratio / (2 * 64)
   always_comb begin
      case (mode)
         CLK_M128: div_last = DIV_W'(0);
         CLK_M512: div_last = DIV_W'(3);
         default:  div_last = DIV_W'(1);
      endcase
   end

   assign toggle  = run && mclk_tick && (div_q == div_last);
   assign ev      = toggle && bclk_q;
   assign ev_slot = slot_q + SLOT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bclk_q <= 1'b0;
         slot_q <= '1;
         lr_q   <= 1'b0;
      end else if (!run) begin
         div_q  <= '0;
         bclk_q <= 1'b0;
         slot_q <= '1;
         lr_q   <= 1'b0;
      end else if (mclk_tick) begin
         if (toggle) begin
            div_q  <= '0;
            bclk_q <= !bclk_q;
            if (bclk_q) begin
               slot_q <= ev_slot;
               lr_q   <= ev_slot[SLOT_W-1] ^ !i2s;
            end
         end else begin
            div_q <= div_q + DIV_W'(1);
         end
      end
   end

   assign bclk = bclk_q;
   assign lrck = lr_q;

endmodule

// File: rtl/sao_slave_track.sv
module sao_slave_track
   import sao_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            i2s,
   input  logic            bclk_in,
   input  logic            lrck_in,
   output logic            ev,
   output logic            ev_half,
   output logic [K_W-1:0]  ev_k
);

   logic [SYNC_STAGES-1:0] bsync, lsync;
   logic bclk_s, lr_s, bprev, lprev, started, fall, lr_edge;
   logic [K_W-1:0] k_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bsync[i] <= 1'b0;
               lsync[i] <= 1'b0;
            end else if (i == 0) begin
               bsync[i] <= bclk_in;
               lsync[i] <= lrck_in;
            end else begin
               bsync[i] <= bsync[(i == 0) ? 0 : i-1];
               lsync[i] <= lsync[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign bclk_s  = bsync[SYNC_STAGES-1];
   assign lr_s    = lsync[SYNC_STAGES-1];
   assign fall    = bprev && !bclk_s;
   assign lr_edge = lr_s != lprev;

   assign ev      = run && fall && (started || lr_edge);
   assign ev_half = i2s ? lr_s : !lr_s;
   assign ev_k    = lr_edge ? '0 : ((k_q == '1) ? k_q : k_q + K_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bprev   <= 1'b0;
         lprev   <= 1'b0;
         started <= 1'b0;
         k_q     <= '0;
      end else begin
         bprev <= bclk_s;
         if (!run) begin
            lprev   <= lr_s;
            started <= 1'b0;
            k_q     <= '0;
         end else if (fall) begin
            lprev <= lr_s;
            k_q   <= ev_k;
            if (lr_edge) started <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sao_shifter.sv
module sao_shifter
   import sao_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                ev,
   input  logic                half,
   input  logic [K_W-1:0]      k,
   input  logic                i2s,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                in_ready,
   output logic                sdata
);

   logic                pend_v;
   logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, word, shifted;
   logic [K_W-1:0]      pos;
   logic                frame_start, load, accept, bit_n, sd_q;

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > HALF_SLOTS - 1) begin : g_bad_width
         $error("SAMPLE_W must fit a half frame with one slot of offset");
      end
   endgenerate

   assign frame_start = ev && !half && (k == '0);
   assign load        = frame_start && pend_v;
   assign in_ready    = run && !pend_v;
   assign accept      = in_valid && in_ready;

   assign word    = half ? cur_r : (load ? pend_l : cur_l);
   assign pos     = k - K_W'(i2s);
   assign shifted = word << pos;
   assign bit_n   = !(i2s && (k == '0)) && shifted[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_l <= '0;
         pend_r <= '0;
         cur_l  <= '0;
         cur_r  <= '0;
         sd_q   <= 1'b0;
      end else if (!run) begin
         pend_v <= 1'b0;
         pend_l <= '0;
         pend_r <= '0;
         cur_l  <= '0;
         cur_r  <= '0;
         sd_q   <= 1'b0;
      end else begin
         if (ev) sd_q <= bit_n;
         if (load) begin
            cur_l  <= pend_l;
            cur_r  <= pend_r;
            pend_v <= 1'b0;
         end
         if (accept) begin
            pend_l <= in_left;
            pend_r <= in_right;
            pend_v <= 1'b1;
         end
      end
   end

   assign sdata = sd_q;

endmodule

// File: rtl/sao_serial_out.sv
module sao_serial_out
   import sao_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pd_i,
   input  logic [1:0]          clk_mode_i,
   input  logic                fmt_i2s_i,
   input  logic                mclk_tick_i,
   input  logic                bclk_i,
   input  logic                lrck_i,
   output logic                bclk_o,
   output logic                lrck_o,
   output logic                clk_drive_o,
   output logic                sdata_o,
   input  logic                in_valid_i,
   output logic                in_ready_o,
   input  logic [SAMPLE_W-1:0] in_left_i,
   input  logic [SAMPLE_W-1:0] in_right_i
);

   clk_mode_e      cfg_mode;
   logic           cfg_i2s;
   logic           is_master, run_m, run_s;
   logic           m_ev, s_ev, s_half, ev, half;
   logic [SLOT_W-1:0] m_slot;
   logic [K_W-1:0] s_k, k;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode <= CLK_M256;
         cfg_i2s  <= 1'b0;
      end else if (pd_i) begin
         cfg_mode <= clk_mode_e'(clk_mode_i);
         cfg_i2s  <= fmt_i2s_i;
      end
   end

   assign is_master   = cfg_mode != CLK_SLAVE;
   assign run_m       = !pd_i && is_master;
   assign run_s       = !pd_i && !is_master;
   assign clk_drive_o = is_master;

   sao_master_gen u_mgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_m),
      .mclk_tick (mclk_tick_i),
      .mode      (cfg_mode),
      .i2s       (cfg_i2s),
      .ev        (m_ev),
      .ev_slot   (m_slot),
      .bclk      (bclk_o),
      .lrck      (lrck_o)
   );

   sao_slave_track #(.SYNC_STAGES(SYNC_STAGES)) u_strk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_s),
      .i2s     (cfg_i2s),
      .bclk_in (bclk_i),
      .lrck_in (lrck_i),
      .ev      (s_ev),
      .ev_half (s_half),
      .ev_k    (s_k)
   );

   assign ev   = is_master ? m_ev : s_ev;
   assign half = is_master ? m_slot[SLOT_W-1] : s_half;
   assign k    = is_master ? m_slot[K_W-1:0] : s_k;

   sao_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (!pd_i),
      .ev       (ev),
      .half     (half),
      .k        (k),
      .i2s      (cfg_i2s),
      .in_valid (in_valid_i),
      .in_left  (in_left_i),
      .in_right (in_right_i),
      .in_ready (in_ready_o),
      .sdata    (sdata_o)
   );

endmodule

// File: rtl/sao_serial_out_chk.sv
module sao_serial_out_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pd_i,
   input logic       in_valid_i,
   input logic       in_ready_o,
   input logic       sdata_o,
   input logic       bclk_o,
   input logic       lrck_o,
   input logic       clk_drive_o,
   input logic [1:0] cfg_mode,
   input logic       cfg_i2s
);

   // R9: configuration frozen while powered up
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_i |=> ($stable(cfg_mode) && $stable(cfg_i2s)));

   // R10: outputs quiet after a power-down cycle
   p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |=> (!sdata_o && !bclk_o && !lrck_o));

   p_pd_noready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |-> !in_ready_o);

   // R2: slave mode leaves the clock outputs idle
   p_slave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b01) |-> (!bclk_o && !lrck_o && !clk_drive_o));

   // R4: data and frame clock move only with a bit-clock fall in master mode
   p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b01 && !pd_i && !$past(pd_i) && sdata_o != $past(sdata_o))
         |-> ($past(bclk_o) && !bclk_o));

   p_lr_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b01 && !pd_i && !$past(pd_i) && lrck_o != $past(lrck_o))
         |-> ($past(bclk_o) && !bclk_o));

   // R8: ready holds until a transfer or a power-down
   p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready_o && !in_valid_i && !pd_i) |=> (in_ready_o || pd_i));

endmodule

bind sao_serial_out sao_serial_out_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pd_i        (pd_i),
   .in_valid_i  (in_valid_i),
   .in_ready_o  (in_ready_o),
   .sdata_o     (sdata_o),
   .bclk_o      (bclk_o),
   .lrck_o      (lrck_o),
   .clk_drive_o (clk_drive_o),
   .cfg_mode    (cfg_mode),
   .cfg_i2s     (cfg_i2s)
);

// File: tb/sao_serial_out_tb_top.sv
module sao_serial_out_tb_top;

   localparam int HP = 6;

   logic clk = 1'b0;
   logic rst_n, pd, fmt, mtick, bclk_in, lrck_in, valid;
   logic [1:0]  cmode;
   logic [23:0] left, right;
   logic bclk_o, lrck_o, drive, sdata, ready;
   int n_chk = 0;
   int n_err = 0;

   always #5 clk = !clk;

   sao_serial_out dut_i (
      .clk(clk), .rst_n(rst_n), .pd_i(pd), .clk_mode_i(cmode), .fmt_i2s_i(fmt),
      .mclk_tick_i(mtick), .bclk_i(bclk_in), .lrck_i(lrck_in),
      .bclk_o(bclk_o), .lrck_o(lrck_o), .clk_drive_o(drive), .sdata_o(sdata),
      .in_valid_i(valid), .in_ready_o(ready), .in_left_i(left), .in_right_i(right)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // slot s of a half carries bit (23 - (s - off)) while that index is in range
   function automatic logic [31:0] exp_half(logic [23:0] w, bit off, int n);
      logic [31:0] r = '0;
      for (int s = 0; s < 32; s++) begin
         int p = s - int'(off);
         if (s < n && p >= 0 && p < 24) r[s] = w[23-p];
      end
      return r;
   endfunction

   task automatic power_cfg(input logic [1:0] m, input bit f);
      @(negedge clk);
      pd = 1'b1; cmode = m; fmt = f;
      repeat (3) @(negedge clk);
      pd = 1'b0;
   endtask

   task automatic push(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      valid = 1'b1; left = l; right = r;
      while (!ready) @(negedge clk);
      @(negedge clk);
      valid = 1'b0;
   endtask

   task automatic cap_master(input bit lvl, output logic [31:0] lb, output logic [31:0] rb,
                             output logic [63:0] lrv, output int flen, output int bad_edge);
      int t = 0, slot = -1, st = 0;
      logic pb = bclk_o, plr = lrck_o, psd = sdata;
      lb = '0; rb = '0; lrv = '0; flen = -1; bad_edge = 0;
      while (t < 4000) begin
         @(negedge clk); t++;
         if (slot >= 0 && sdata !== psd && !(pb && !bclk_o)) bad_edge++;
         if (!pb && bclk_o) begin
            if (slot == 64) begin
               if (lrck_o == lvl && plr != lvl) flen = t - st;
               return;
            end
            if (slot < 0 && lrck_o == lvl && plr != lvl) begin slot = 0; st = t; end
            if (slot >= 0) begin
               lrv[slot] = lrck_o;
               if (slot < 32) lb[slot] = sdata; else rb[slot-32] = sdata;
               slot++;
            end
            plr = lrck_o;
         end
         pb = bclk_o; psd = sdata;
      end
   endtask

   task automatic slave_frame(input int n, input bit lvl, output logic [31:0] lb, output logic [31:0] rb);
      lb = '0; rb = '0;
      for (int h = 0; h < 2; h++) begin
         for (int s = 0; s < n; s++) begin
            bclk_in = 1'b0;
            if (s == 0) lrck_in = (h == 0) ? lvl : !lvl;
            repeat (HP) @(negedge clk);
            if (h == 0) lb[s] = sdata; else rb[s] = sdata;
            bclk_in = 1'b1;
            repeat (HP) @(negedge clk);
         end
      end
   endtask

   task automatic t_reset;
      chk("R10 reset sdata", 64'(sdata), 64'd0);
      chk("R10 reset bclk/lrck", 64'({bclk_o, lrck_o}), 64'd0);
      chk("R10 reset ready", 64'(ready), 64'd0);
   endtask

   task automatic t_master(input logic [1:0] m, input bit f, input int ratio, input string tag);
      logic [31:0] lb, rb; logic [63:0] lrv, lrexp; int flen, be;
      logic [23:0] a_l, a_r, b_l, b_r;
      a_l = 24'hA5C3_0F ^ {22'd0, m}; a_r = 24'h5A1E_93; b_l = 24'h80_0001; b_r = 24'h7F_FFFE ^ {23'd0, f};
      lrexp = f ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
      power_cfg(m, f);
      chk({tag, " R1 drive flag"}, 64'(drive), 64'd1);
      push(a_l, a_r);
      cap_master(!f, lb, rb, lrv, flen, be);
      cap_master(!f, lb, rb, lrv, flen, be);
      chk({tag, " R1 frame length"}, 64'(flen), 64'(ratio));
      chk({tag, " R3 left word"}, 64'(lb), 64'(exp_half(a_l, f, 32)));
      chk({tag, " R3 right word"}, 64'(rb), 64'(exp_half(a_r, f, 32)));
      chk({tag, f ? " R6 frame clock polarity" : " R5 frame clock polarity"}, lrv, lrexp);
      chk({tag, " R4 data only on bclk fall"}, 64'(be), 64'd0);
      push(b_l, b_r);
      cap_master(!f, lb, rb, lrv, flen, be);
      cap_master(!f, lb, rb, lrv, flen, be);
      chk({tag, " R8 new pair"}, {rb, lb}, {exp_half(b_r, f, 32), exp_half(b_l, f, 32)});
      cap_master(!f, lb, rb, lrv, flen, be);
      chk({tag, " R8 repeat pair"}, {rb, lb}, {exp_half(b_r, f, 32), exp_half(b_l, f, 32)});
   endtask

   task automatic t_cfg_ignore;
      logic [31:0] lb, rb; logic [63:0] lrv; int flen, be;
      power_cfg(2'b00, 1'b0);
      push(24'h12_3456, 24'hFE_DCBA);
      @(negedge clk);
      cmode = 2'b11; fmt = 1'b1;
      cap_master(1'b1, lb, rb, lrv, flen, be);
      cap_master(1'b1, lb, rb, lrv, flen, be);
      chk("R9 ratio unchanged", 64'(flen), 64'd256);
      chk("R9 format unchanged", {rb, lb}, {exp_half(24'hFE_DCBA, 0, 32), exp_half(24'h12_3456, 0, 32)});
   endtask

   task automatic t_pd_mid;
      logic [31:0] lb, rb; logic [63:0] lrv; int flen, be;
      power_cfg(2'b11, 1'b0);
      push(24'hFF_FFFF, 24'hFF_FFFF);
      repeat (300) @(negedge clk);
      pd = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 power-down outputs", 64'({sdata, bclk_o, lrck_o, ready}), 64'd0);
      pd = 1'b0;
      @(negedge clk);
      chk("R10 buffer cleared (ready)", 64'(ready), 64'd1);
      cap_master(1'b1, lb, rb, lrv, flen, be);
      cap_master(1'b1, lb, rb, lrv, flen, be);
      chk("R10 current pair cleared", {rb, lb}, 64'd0);
   endtask

   task automatic t_slave(input int n, input bit f, input logic [23:0] l, input logic [23:0] r, input string tag);
      logic [31:0] lb, rb;
      @(negedge clk);
      bclk_in = 1'b1; lrck_in = f;
      power_cfg(2'b01, f);
      repeat (4) @(negedge clk);
      push(l, r);
      slave_frame(n, !f, lb, rb);
      slave_frame(n, !f, lb, rb);
      chk({tag, " left word"}, 64'(lb), 64'(exp_half(l, f, n)));
      chk({tag, " right word"}, 64'(rb), 64'(exp_half(r, f, n)));
      chk("R2 slave clock outputs idle", 64'({bclk_o, lrck_o, drive}), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pd = 1'b1; cmode = 2'b00; fmt = 1'b0; mtick = 1'b1;
      bclk_in = 1'b1; lrck_in = 1'b0; valid = 1'b0; left = '0; right = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_master(2'b00, 1'b0, 256, "M256 MSBJ R5");
      t_master(2'b10, 1'b1, 512, "M512 I2S R6");
      t_master(2'b11, 1'b0, 128, "M128 MSBJ");
      t_cfg_ignore();
      t_pd_mid();
      t_slave(24, 1'b0, 24'hC3_5A96, 24'h1F_E0A5, "R2 R3 slave48 MSBJ");
      t_slave(16, 1'b0, 24'hB6_D9E7, 24'h4A_5C3F, "R7 slave32 MSBJ");
      t_slave(24, 1'b1, 24'h93_0C6F, 24'h6C_F391, "R6 R7 slave48 I2S");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule